// File: doc/BRIEF.md
# FIFO Data-Loss Exception Monitor

This block observes the handshake lines around a FIFO stage that never stalls its producer or its consumer. Such a stage has no way to push back, so some handshake patterns mean a word was lost or the occupancy state is inconsistent. Every clock cycle the monitor checks the current handshake values. For each exception class that holds, it raises one line of a registered pulse vector during the next cycle.

A compile-time parameter picks one of two port sets. One set is for a plain synchronous FIFO. The other is for a packer FIFO, which also has a write-ready line. The inputs of the port set that is not selected have no effect. Overflow, underflow and the full-but-not-valid condition count as fatal. A write into a packer that is not ready counts as recoverable. Each class drives its own sticky alert. An alert stays high until an explicit clear input drops it.

Top module: `fifo_loss_monitor`

## Requirements
- R1: Bit 0 of `err_pulse_o` (overflow) is high in the cycle after any cycle in which the selected push input is high while the selected full input is high.
- R2: Bit 1 of `err_pulse_o` (underflow) is high in the cycle after any cycle in which the selected pop input is high while the selected pop-valid input is low.
- R3: Bit 2 of `err_pulse_o` (state error) is high in the cycle after any cycle in which the selected full input is high while the selected pop-valid input is low.
- R4: With `PACKER_MODE`=1, bit 3 of `err_pulse_o` (write while not ready) is high in the cycle after any cycle in which `pk_push_i` is high while `pk_push_ready_i` is low.
- R5: With `PACKER_MODE`=0, bit 3 of `err_pulse_o` is always 0, and the `pk_*` inputs have no effect on any output. With `PACKER_MODE`=1, the `sf_*` inputs have no effect on any output.
- R6: Each pulse bit is high for one cycle for each cycle in which its condition held, and low otherwise. A condition that holds for N cycles in a row gives N high cycles in a row.
- R7: `fatal_alert_o` goes high in the cycle after any of pulse bits 0 to 2 is high. It then stays high until it is cleared.
- R8: `recov_alert_o` goes high in the cycle after pulse bit 3 is high. It then stays high until it is cleared.
- R9: When `alert_clr_i` is high in a cycle, each alert is low in the next cycle. The exception is an alert whose class has a pulse bit high in that same cycle: that alert stays high.
- R10: The reset is synchronous and active high. After any clock edge with `rst_i` high, all pulse bits and both alerts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sf_push_i | input | 1 | Synchronous FIFO: write valid |
| sf_full_i | input | 1 | Synchronous FIFO: full flag |
| sf_pop_i | input | 1 | Synchronous FIFO: read ready |
| sf_pop_valid_i | input | 1 | Synchronous FIFO: read valid (not empty) |
| pk_push_i | input | 1 | Packer FIFO: write valid |
| pk_push_ready_i | input | 1 | Packer FIFO: write ready |
| pk_full_i | input | 1 | Packer FIFO: full flag |
| pk_pop_i | input | 1 | Packer FIFO: read ready |
| pk_pop_valid_i | input | 1 | Packer FIFO: read valid |
| alert_clr_i | input | 1 | Clears both sticky alerts |
| err_pulse_o | output | 4 | Exception pulses: bit 0 overflow, bit 1 underflow, bit 2 state, bit 3 write not ready |
| fatal_alert_o | output | 1 | Sticky fatal alert |
| recov_alert_o | output | 1 | Sticky recoverable alert |

## Verification
A pulse bit is due one clock edge after the cycle that holds its condition. An alert follows one edge after the pulse, so it is two edges after the condition. A clear takes effect at the first edge after it is applied. The bench drives every input at the falling edge and advances its reference model once for each rising edge. It compares the outputs at the next falling edge, so each result is checked in exactly the cycle it is due. Two instances, one per mode, share the same stimulus, so the inputs of the unused port set are always random noise that must leave the outputs unchanged.

// File: rtl/fifo_loss_pkg.sv
package fifo_loss_pkg;

  // Position of each exception class in the pulse vector
  typedef enum int unsigned {
    EXC_OVERFLOW     = 0,
    EXC_UNDERFLOW    = 1,
    EXC_STATE        = 2,
    EXC_WR_NOT_READY = 3
  } exc_e;

  localparam int unsigned NUM_EXC = 4;

  // Class membership of each pulse line
  localparam logic [NUM_EXC-1:0] FATAL_MASK = 4'b0111;
  localparam logic [NUM_EXC-1:0] RECOV_MASK = 4'b1000;

endpackage

// File: rtl/fifo_loss_detect.sv
module fifo_loss_detect
  import fifo_loss_pkg::*;
#(
  parameter bit PACKER_MODE = 1'b0
) (
  input  logic               sf_push_i,
  input  logic               sf_full_i,
  input  logic               sf_pop_i,
  input  logic               sf_pop_valid_i,
  input  logic               pk_push_i,
  input  logic               pk_push_ready_i,
  input  logic               pk_full_i,
  input  logic               pk_pop_i,
  input  logic               pk_pop_valid_i,
  output logic [NUM_EXC-1:0] cond_o
);

  generate
    if (PACKER_MODE) begin : g_packer
      logic unused_sf;
      assign unused_sf = ^{sf_push_i, sf_full_i, sf_pop_i, sf_pop_valid_i};

      always_comb begin
        cond_o                   = '0;
        cond_o[EXC_OVERFLOW]     = pk_push_i & pk_full_i;
        cond_o[EXC_UNDERFLOW]    = pk_pop_i & ~pk_pop_valid_i;
        cond_o[EXC_STATE]        = pk_full_i & ~pk_pop_valid_i;
        cond_o[EXC_WR_NOT_READY] = pk_push_i & ~pk_push_ready_i;
      end
    end else begin : g_sync
      logic unused_pk;
      assign unused_pk = ^{pk_push_i, pk_push_ready_i, pk_full_i,
                           pk_pop_i, pk_pop_valid_i};

      always_comb begin
        cond_o                   = '0;
        cond_o[EXC_OVERFLOW]     = sf_push_i & sf_full_i;
        cond_o[EXC_UNDERFLOW]    = sf_pop_i & ~sf_pop_valid_i;
        cond_o[EXC_STATE]        = sf_full_i & ~sf_pop_valid_i;
        cond_o[EXC_WR_NOT_READY] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/fifo_loss_pulse_reg.sv
module fifo_loss_pulse_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] cond_i,
  output logic [WIDTH-1:0] pulse_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) pulse_o <= '0;
    else       pulse_o <= cond_i;
  end

endmodule

// File: rtl/fifo_loss_alert_latch.sv
module fifo_loss_alert_latch #(
  parameter int unsigned      WIDTH = 4,
  parameter logic [WIDTH-1:0] MASK  = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] pulse_i,
  input  logic             clr_i,
  output logic             alert_o
);

  logic hit;
  assign hit = |(pulse_i & MASK);

  // A new event in the clear cycle wins, so no event is dropped
  always_ff @(posedge clk_i) begin
    if (rst_i) alert_o <= 1'b0;
    else       alert_o <= (alert_o & ~clr_i) | hit;
  end

endmodule

// File: rtl/fifo_loss_monitor.sv
module fifo_loss_monitor
  import fifo_loss_pkg::*;
#(
  parameter bit PACKER_MODE = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               sf_push_i,
  input  logic               sf_full_i,
  input  logic               sf_pop_i,
  input  logic               sf_pop_valid_i,
  input  logic               pk_push_i,
  input  logic               pk_push_ready_i,
  input  logic               pk_full_i,
  input  logic               pk_pop_i,
  input  logic               pk_pop_valid_i,
  input  logic               alert_clr_i,
  output logic [NUM_EXC-1:0] err_pulse_o,
  output logic               fatal_alert_o,
  output logic               recov_alert_o
);

  logic [NUM_EXC-1:0] cond;

  fifo_loss_detect #(.PACKER_MODE(PACKER_MODE)) u_detect (
    .sf_push_i       (sf_push_i),
    .sf_full_i       (sf_full_i),
    .sf_pop_i        (sf_pop_i),
    .sf_pop_valid_i  (sf_pop_valid_i),
    .pk_push_i       (pk_push_i),
    .pk_push_ready_i (pk_push_ready_i),
    .pk_full_i       (pk_full_i),
    .pk_pop_i        (pk_pop_i),
    .pk_pop_valid_i  (pk_pop_valid_i),
    .cond_o          (cond)
  );

  fifo_loss_pulse_reg #(.WIDTH(NUM_EXC)) u_pulse (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .cond_i  (cond),
    .pulse_o (err_pulse_o)
  );

  fifo_loss_alert_latch #(.WIDTH(NUM_EXC), .MASK(FATAL_MASK)) u_fatal (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .pulse_i (err_pulse_o),
    .clr_i   (alert_clr_i),
    .alert_o (fatal_alert_o)
  );

  fifo_loss_alert_latch #(.WIDTH(NUM_EXC), .MASK(RECOV_MASK)) u_recov (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .pulse_i (err_pulse_o),
    .clr_i   (alert_clr_i),
    .alert_o (recov_alert_o)
  );

endmodule

// File: rtl/fifo_loss_monitor_chk.sv
module fifo_loss_monitor_chk #(
  parameter bit PACKER_MODE = 1'b0
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       sf_push_i,
  input logic       sf_full_i,
  input logic       sf_pop_i,
  input logic       sf_pop_valid_i,
  input logic       pk_push_i,
  input logic       pk_push_ready_i,
  input logic       pk_full_i,
  input logic       pk_pop_i,
  input logic       pk_pop_valid_i,
  input logic       alert_clr_i,
  input logic [3:0] err_pulse_o,
  input logic       fatal_alert_o,
  input logic       recov_alert_o
);

  logic push, full, pop, popv;
  assign push = PACKER_MODE ? pk_push_i      : sf_push_i;
  assign full = PACKER_MODE ? pk_full_i      : sf_full_i;
  assign pop  = PACKER_MODE ? pk_pop_i       : sf_pop_i;
  assign popv = PACKER_MODE ? pk_pop_valid_i : sf_pop_valid_i;

  AST_OVERFLOW_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    (push && full) |=> err_pulse_o[0]); // R1
  AST_OVERFLOW_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    !(push && full) |=> !err_pulse_o[0]); // R6
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    (pop && !popv) |=> err_pulse_o[1]); // R2
  AST_STATE_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    (full && !popv) |=> err_pulse_o[2]); // R3
  AST_FATAL_SET: assert property (@(posedge clk_i) disable iff (rst_i)
    (|err_pulse_o[2:0]) |=> fatal_alert_o); // R7
  AST_FATAL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (fatal_alert_o && !alert_clr_i) |=> fatal_alert_o); // R7
  AST_RECOV_SET: assert property (@(posedge clk_i) disable iff (rst_i)
    err_pulse_o[3] |=> recov_alert_o); // R8
  AST_RECOV_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (recov_alert_o && !alert_clr_i) |=> recov_alert_o); // R8
  AST_FATAL_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    (alert_clr_i && !(|err_pulse_o[2:0])) |=> !fatal_alert_o); // R9

  generate
    if (PACKER_MODE) begin : g_pk_chk
      AST_WNR_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (pk_push_i && !pk_push_ready_i) |=> err_pulse_o[3]); // R4
    end else begin : g_sf_chk
      AST_WNR_SYNC_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        sf_push_i |-> !err_pulse_o[3]); // R5
    end
  endgenerate

endmodule

bind fifo_loss_monitor fifo_loss_monitor_chk #(.PACKER_MODE(PACKER_MODE)) u_chk (
  .clk_i           (clk_i),
  .rst_i           (rst_i),
  .sf_push_i       (sf_push_i),
  .sf_full_i       (sf_full_i),
  .sf_pop_i        (sf_pop_i),
  .sf_pop_valid_i  (sf_pop_valid_i),
  .pk_push_i       (pk_push_i),
  .pk_push_ready_i (pk_push_ready_i),
  .pk_full_i       (pk_full_i),
  .pk_pop_i        (pk_pop_i),
  .pk_pop_valid_i  (pk_pop_valid_i),
  .alert_clr_i     (alert_clr_i),
  .err_pulse_o     (err_pulse_o),
  .fatal_alert_o   (fatal_alert_o),
  .recov_alert_o   (recov_alert_o)
);

// File: tb/fifo_loss_monitor_bench.sv
`timescale 1ns/1ps
module fifo_loss_monitor_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic sf_push = 0, sf_full = 0, sf_pop = 0, sf_popv = 0;
  logic pk_push = 0, pk_rdy = 0, pk_full = 0, pk_pop = 0, pk_popv = 0;
  logic clr = 0;

  logic [3:0] s_err, p_err;
  logic       s_fatal, s_recov, p_fatal, p_recov;

  fifo_loss_monitor #(.PACKER_MODE(1'b0)) u_fifo_loss_monitor (
    .clk_i(clk), .rst_i(rst),
    .sf_push_i(sf_push), .sf_full_i(sf_full), .sf_pop_i(sf_pop), .sf_pop_valid_i(sf_popv),
    .pk_push_i(pk_push), .pk_push_ready_i(pk_rdy), .pk_full_i(pk_full),
    .pk_pop_i(pk_pop), .pk_pop_valid_i(pk_popv),
    .alert_clr_i(clr), .err_pulse_o(s_err), .fatal_alert_o(s_fatal), .recov_alert_o(s_recov)
  );

  fifo_loss_monitor #(.PACKER_MODE(1'b1)) u_fifo_loss_monitor_pk (
    .clk_i(clk), .rst_i(rst),
    .sf_push_i(sf_push), .sf_full_i(sf_full), .sf_pop_i(sf_pop), .sf_pop_valid_i(sf_popv),
    .pk_push_i(pk_push), .pk_push_ready_i(pk_rdy), .pk_full_i(pk_full),
    .pk_pop_i(pk_pop), .pk_pop_valid_i(pk_popv),
    .alert_clr_i(clr), .err_pulse_o(p_err), .fatal_alert_o(p_fatal), .recov_alert_o(p_recov)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit armed = 0;

  // Reference state per mode: index 0 synchronous, 1 packer
  logic [3:0] exp_err [2];
  logic       exp_fatal [2];
  logic       exp_recov [2];

  // R1..R5: condition vector from the selected port set
  function automatic logic [3:0] cond_f(input int mode);
    logic [3:0] c;
    if (mode == 1) begin
      c[0] = pk_push & pk_full;
      c[1] = pk_pop & ~pk_popv;
      c[2] = pk_full & ~pk_popv;
      c[3] = pk_push & ~pk_rdy;
    end else begin
      c[0] = sf_push & sf_full;
      c[1] = sf_pop & ~sf_popv;
      c[2] = sf_full & ~sf_popv;
      c[3] = 1'b0;
    end
    return c;
  endfunction

  function automatic string bit_tag(input int mode, input int b);
    case (b)
      0: return "R1/R6 overflow";
      1: return "R2/R6 underflow";
      2: return "R3/R6 state";
      default: return (mode == 1) ? "R4 write-not-ready" : "R5 sync bit3 low";
    endcase
  endfunction

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    for (int m = 0; m < 2; m++) begin
      logic [3:0] e;
      logic f, r;
      string mt;
      e  = (m == 1) ? p_err   : s_err;
      f  = (m == 1) ? p_fatal : s_fatal;
      r  = (m == 1) ? p_recov : s_recov;
      mt = (m == 1) ? " [packer]" : " [sync]";
      for (int b = 0; b < 4; b++) begin
        check1({rst ? "R10 " : "", bit_tag(m, b), mt}, e[b], exp_err[m][b]);
      end
      check1({"R7/R9 fatal", mt}, f, exp_fatal[m]);
      check1({"R8/R9 recov", mt}, r, exp_recov[m]);
    end
  endtask

  // One cycle: check due results, drive, then advance the model by one edge
  task automatic cycle(input logic r_v, input logic c_v, input logic [3:0] sf_v, input logic [4:0] pk_v);
    @(negedge clk);
    if (armed) check_all();
    rst = r_v; clr = c_v;
    {sf_push, sf_full, sf_pop, sf_popv} = sf_v;
    {pk_push, pk_rdy, pk_full, pk_pop, pk_popv} = pk_v;
    for (int m = 0; m < 2; m++) begin
      if (r_v) begin
        exp_fatal[m] = 1'b0;
        exp_recov[m] = 1'b0;
        exp_err[m]   = 4'b0;
      end else begin
        exp_fatal[m] = (exp_fatal[m] & ~c_v) | (|exp_err[m][2:0]);
        exp_recov[m] = (exp_recov[m] & ~c_v) | exp_err[m][3];
        exp_err[m]   = cond_f(m);
      end
    end
    armed = 1;
  endtask

  // Quiet inputs: no condition in either mode
  localparam logic [3:0] SF_IDLE = 4'b0001;
  localparam logic [4:0] PK_IDLE = 5'b01001;

  task automatic rand_cycle();
    logic [3:0] s;
    logic [4:0] p;
    logic c;
    s = 4'($urandom);
    p = 5'($urandom);
    // Bias toward healthy handshakes so alerts get cleared and re-armed
    if ($urandom_range(0, 2) != 0) s = (s & 4'b1010) | 4'b0001;
    if ($urandom_range(0, 2) != 0) p = (p & 5'b10010) | 5'b01001;
    c = ($urandom_range(0, 5) == 0);
    cycle(1'b0, c, s, p);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < 2; m++) begin
      exp_err[m] = '0; exp_fatal[m] = 0; exp_recov[m] = 0;
    end
    // R10: reset with error conditions present on every input
    cycle(1'b1, 1'b0, 4'b1110, 5'b10110);
    cycle(1'b1, 1'b0, 4'b1110, 5'b10110);
    cycle(1'b0, 1'b0, SF_IDLE, PK_IDLE);
    // R6: sustained overflow for three cycles, then quiet
    repeat (3) cycle(1'b0, 1'b0, 4'b1101, 5'b11101);
    // R7/R8: alerts hold through idle cycles
    repeat (4) cycle(1'b0, 1'b0, SF_IDLE, PK_IDLE);
    // R4: write into non-ready packer only
    cycle(1'b0, 1'b0, SF_IDLE, 5'b10001);
    repeat (3) cycle(1'b0, 1'b0, SF_IDLE, PK_IDLE);
    // R9: clear alone drops alerts
    cycle(1'b0, 1'b1, SF_IDLE, PK_IDLE);
    repeat (2) cycle(1'b0, 1'b0, SF_IDLE, PK_IDLE);
    // R9: clear in the same cycle as a pulse keeps the alert set
    cycle(1'b0, 1'b0, 4'b0010, 5'b10011);
    cycle(1'b0, 1'b1, SF_IDLE, PK_IDLE);
    repeat (2) cycle(1'b0, 1'b0, SF_IDLE, PK_IDLE);
    // R2/R3: underflow and state error individually
    cycle(1'b0, 1'b0, 4'b0010, 5'b01010);
    cycle(1'b0, 1'b0, 4'b0100, 5'b01100);
    repeat (2) cycle(1'b0, 1'b0, SF_IDLE, PK_IDLE);
    // R5 and the rest: random mix, with unused port set acting as noise
    for (int i = 0; i < 3000; i++) begin
      rand_cycle();
      if ($urandom_range(0, 499) == 0) cycle(1'b1, 1'b0, 4'($urandom), 5'($urandom));
    end
    cycle(1'b0, 1'b0, SF_IDLE, PK_IDLE);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000ns;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule